// File: doc/BRIEF.md
# Silent-Input Automute Detector

This block watches the six 24-bit audio channels carried on three stereo serial data lines and raises a mute flag once every sample it sees has been exactly zero for a long unbroken run of frames. The default run is 24000 frames, about half a second at a 48 kHz frame rate. Each frame arrives as a parallel snapshot of all six channels with a one-cycle valid strobe. A frame with any nonzero sample ends the run at once and drops the mute flag in the same cycle. Gaps between frame strobes neither add to the run nor break it.

Two control inputs can suppress detection. One is an active-low automute enable, where 0 allows muting, which is the state after reset. The other is a test disable, where 1 turns the feature off. While either one suppresses detection, every flag is forced low and the run length is held at zero. A fresh full run is needed once detection is allowed again. Alongside the global flag, the block gives one flag per stereo line. Each of these follows the same rule applied to that line's two channels alone. The global flag is high exactly when all three line flags are high.

Top module: `zmute_top`

## Requirements
- R1: After synchronous reset `rst`, the global and all line mute flags are low, and every run length restarts from zero.
- R2: With detection allowed, the global mute flag goes high in the cycle after the strobe of the ZERO_FRAMES-th consecutive all-zero frame. After ZERO_FRAMES-1 such frames it is still low.
- R3: A strobed frame with any nonzero sample drives the global mute flag low in that same cycle. A new full run of ZERO_FRAMES zero frames is then needed before it rises again.
- R4: Cycles without a frame strobe do not count toward a run and do not break it. The sample bus is ignored in those cycles.
- R5: The run length saturates at ZERO_FRAMES and does not wrap. The mute flag stays high through any number of further zero frames.
- R6: While `auto_mute_off` is 1, all mute flags are low in that same cycle and the run lengths are held at zero. After it returns to 0, a full run of ZERO_FRAMES zero frames is needed.
- R7: While `zero_det_off` is 1, the behaviour is the same as in R6.
- R8: Line k (k = 0, 1, 2) carries channel 2k as left and channel 2k+1 as right. Channel c occupies bits [24c+23:24c] of `sample_bus`. `line_mute[k]` follows the rules of R2 to R5 using only the two channels of line k, independent of the other lines.
- R9: `mute` is high exactly when all three bits of `line_mute` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe marking a new frame on `sample_bus` |
| sample_bus | input | 144 | Six 24-bit two's complement samples, channel c at bits [24c+23:24c] |
| auto_mute_off | input | 1 | Active-low automute enable: 0 allows muting, 1 suppresses it |
| zero_det_off | input | 1 | Test disable: 1 suppresses zero detection |
| mute | output | 1 | All six channels silent for the full run |
| line_mute | output | 3 | Per-stereo-line silence flags |

## Verification
Every result either becomes due in the cycle of its stimulus or exactly one register later. A nonzero frame or a raised disable input clears the flags combinationally, so these are read in the same cycle while the stimulus is still applied. The run length passes through one counter register per line. The flag therefore rises one clock after the strobe of the last zero frame. The bench drives each input at the falling edge and samples a little later in that half cycle. It checks "not yet" right after frame ZERO_FRAMES-1 and "now" in the idle cycle that follows frame ZERO_FRAMES.

// File: rtl/zmute_pkg.sv
package zmute_pkg;

    localparam int SAMPLE_W = 24;
    localparam int LINES    = 3;
    localparam int CHANNELS = 2 * LINES;
    localparam int LINE_W   = 2 * SAMPLE_W;
    localparam int BUS_W    = CHANNELS * SAMPLE_W;

    typedef logic [SAMPLE_W-1:0] sample_t;

    // left in the low half: channel 2k sits below channel 2k+1 on the bus
    typedef struct packed {
        sample_t right;
        sample_t left;
    } stereo_t;

    typedef enum logic [1:0] {
        RUN_IDLE    = 2'd0,
        RUN_COUNT   = 2'd1,
        RUN_RESTART = 2'd2
    } run_cmd_e;

    function automatic logic stereo_is_silent(input stereo_t s);
        return (s.left == '0) && (s.right == '0);
    endfunction

    function automatic stereo_t line_slice(input logic [BUS_W-1:0] bus, input int k);
        return stereo_t'(bus[k*LINE_W +: LINE_W]);
    endfunction

endpackage

// File: rtl/zmute_frame_scan.sv
module zmute_frame_scan
    import zmute_pkg::*;
(
    input  logic [BUS_W-1:0] sample_bus,
    output logic [LINES-1:0] line_silent
);

    for (genvar k = 0; k < LINES; k++) begin : g_line
        always_comb line_silent[k] = stereo_is_silent(line_slice(sample_bus, k));
    end

endmodule

// File: rtl/zmute_run_counter.sv
module zmute_run_counter
    import zmute_pkg::*;
#(
    parameter int LIMIT = 24000
) (
    input  logic     clk,
    input  logic     rst,
    input  run_cmd_e cmd,
    output logic     full
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    logic [CNT_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else begin
            unique case (cmd)
                RUN_RESTART: run_len <= '0;
                RUN_COUNT:   if (run_len != LIMIT_V) run_len <= run_len + 1'b1;
                default:     run_len <= run_len;
            endcase
        end
    end

    assign full = (run_len == LIMIT_V);

endmodule

// File: rtl/zmute_top.sv
module zmute_top
    import zmute_pkg::*;
#(
    parameter int ZERO_FRAMES = 24000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_valid,
    input  logic [BUS_W-1:0] sample_bus,
    input  logic             auto_mute_off,
    input  logic             zero_det_off,
    output logic             mute,
    output logic [LINES-1:0] line_mute
);

    logic             suppress;
    logic [LINES-1:0] line_silent;
    logic [LINES-1:0] run_full;
    logic [LINES-1:0] break_now;
    run_cmd_e         cmd [LINES];

    assign suppress = auto_mute_off | zero_det_off;

    zmute_frame_scan u_scan (
        .sample_bus  (sample_bus),
        .line_silent (line_silent)
    );

    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign break_now[k] = suppress | (frame_valid & ~line_silent[k]);

        always_comb begin
            if (break_now[k])     cmd[k] = RUN_RESTART;
            else if (frame_valid) cmd[k] = RUN_COUNT;
            else                  cmd[k] = RUN_IDLE;
        end

        zmute_run_counter #(.LIMIT(ZERO_FRAMES)) u_run (
            .clk  (clk),
            .rst  (rst),
            .cmd  (cmd[k]),
            .full (run_full[k])
        );

        assign line_mute[k] = run_full[k] & ~break_now[k];
    end

    // a global run never exceeds the shortest line run, so the AND is exact
    assign mute = &line_mute;

endmodule

// File: rtl/zmute_checker.sv
module zmute_checker
    import zmute_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frame_valid,
    input logic [BUS_W-1:0] sample_bus,
    input logic             auto_mute_off,
    input logic             zero_det_off,
    input logic             mute,
    input logic [LINES-1:0] line_mute
);

    assert_nonzero_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && (sample_bus != '0)) |-> !mute);

    assert_enable_low_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        auto_mute_off |-> (line_mute == '0));

    assert_test_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        zero_det_off |-> (line_mute == '0));

    assert_restart_after_off_R6: assert property (@(posedge clk) disable iff (rst)
        $past(auto_mute_off || zero_det_off) |-> (line_mute == '0));

    assert_rise_on_frame_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mute) |-> $past(frame_valid));

    for (genvar k = 0; k < LINES; k++) begin : g_line
        assert_line_clear_R8: assert property (@(posedge clk) disable iff (rst)
            (frame_valid && !stereo_is_silent(line_slice(sample_bus, k))) |-> !line_mute[k]);
    end

endmodule

bind zmute_top zmute_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_valid   (frame_valid),
    .sample_bus    (sample_bus),
    .auto_mute_off (auto_mute_off),
    .zero_det_off  (zero_det_off),
    .mute          (mute),
    .line_mute     (line_mute)
);

// File: tb/zmute_top_tb.sv
module zmute_top_tb;
    import zmute_pkg::*;

    localparam int N = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             frame_valid;
    logic [BUS_W-1:0] sample_bus;
    logic             auto_mute_off;
    logic             zero_det_off;
    logic             mute;
    logic [LINES-1:0] line_mute;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    zmute_top #(.ZERO_FRAMES(N)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .frame_valid   (frame_valid),
        .sample_bus    (sample_bus),
        .auto_mute_off (auto_mute_off),
        .zero_det_off  (zero_det_off),
        .mute          (mute),
        .line_mute     (line_mute)
    );

    function automatic logic [BUS_W-1:0] one_chan(input int c, input logic [SAMPLE_W-1:0] v);
        logic [BUS_W-1:0] b = '0;
        b[c*SAMPLE_W +: SAMPLE_W] = v;
        return b;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_out(input string req, input logic exp_m, input logic [2:0] exp_l);
        check(mute === exp_m, {req, " mute"}, int'(mute), int'(exp_m));
        check(line_mute === exp_l, {req, " line_mute"}, int'(line_mute), int'(exp_l));
    endtask

    // apply one strobed frame at the falling edge, then settle
    task automatic frame(input logic [BUS_W-1:0] d);
        @(negedge clk);
        frame_valid = 1'b1;
        sample_bus  = d;
        #0.5;
    endtask

    // a cycle without strobe, with junk on the bus
    task automatic gap();
        @(negedge clk);
        frame_valid = 1'b0;
        sample_bus  = {6{24'hA5A5A5}};
        #0.5;
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) frame('0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; frame_valid = 1'b0; sample_bus = '0;
        auto_mute_off = 1'b0; zero_det_off = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #0.5;
    endtask

    task automatic test_reset();
        zeros(N); gap();
        do_reset();
        check_out("R1 after reset", 1'b0, 3'b000);
        zeros(N - 1); gap();
        check_out("R1 run restarted", 1'b0, 3'b000);
    endtask

    task automatic test_threshold();
        do_reset();
        zeros(N - 1); gap();
        check_out("R2 N-1 frames", 1'b0, 3'b000);
        zeros(1);
        check_out("R2 Nth frame same cycle", 1'b0, 3'b000);
        gap();
        check_out("R2 after N frames", 1'b1, 3'b111);
    endtask

    task automatic test_gaps();
        do_reset();
        for (int i = 0; i < N - 1; i++) begin
            frame('0); gap(); gap();
        end
        check_out("R4 gaps no count", 1'b0, 3'b000);
        frame('0); gap();
        check_out("R4 gaps no break", 1'b1, 3'b111);
    endtask

    task automatic test_nonzero();
        do_reset();
        zeros(N); gap();
        frame(one_chan(3, 24'h000001));
        check_out("R3 same cycle clear", 1'b0, 3'b101);
        gap();
        check_out("R3 stays clear", 1'b0, 3'b101);
        zeros(N - 1); gap();
        check_out("R3 needs full run", 1'b0, 3'b101);
        zeros(1); gap();
        check_out("R3 rearmed", 1'b1, 3'b111);
        frame(one_chan(0, 24'h800000));
        check_out("R3 negative sample", 1'b0, 3'b110);
    endtask

    task automatic test_saturate();
        do_reset();
        zeros(5 * N); gap();
        check_out("R5 saturated", 1'b1, 3'b111);
        zeros(3); gap();
        check_out("R5 no wrap", 1'b1, 3'b111);
    endtask

    task automatic test_disable(input bit use_test);
        string tag = use_test ? "R7" : "R6";
        do_reset();
        zeros(N); gap();
        @(negedge clk);
        frame_valid = 1'b0;
        if (use_test) zero_det_off = 1'b1; else auto_mute_off = 1'b1;
        #0.5;
        check_out({tag, " immediate off"}, 1'b0, 3'b000);
        zeros(2 * N); gap();
        check_out({tag, " held off"}, 1'b0, 3'b000);
        @(negedge clk);
        auto_mute_off = 1'b0; zero_det_off = 1'b0;
        zeros(N - 1); gap();
        check_out({tag, " count held zero"}, 1'b0, 3'b000);
        zeros(1); gap();
        check_out({tag, " re-enabled"}, 1'b1, 3'b111);
    endtask

    task automatic test_lines();
        do_reset();
        for (int i = 0; i < N; i++) frame(one_chan(2, 24'h000010));
        gap();
        check_out("R8 line1 busy", 1'b0, 3'b101);
        check(mute === &line_mute, "R9 and of lines", int'(mute), int'(&line_mute));
        frame(one_chan(5, 24'h7FFFFF));
        check_out("R8 line2 right clears", 1'b0, 3'b001);
        zeros(N); gap();
        check_out("R8 all lines quiet", 1'b1, 3'b111);
        check(mute === &line_mute, "R9 and of lines all", int'(mute), int'(&line_mute));
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; frame_valid = 1'b0; sample_bus = '0;
        auto_mute_off = 1'b0; zero_det_off = 1'b0;
        test_reset();
        test_threshold();
        test_gaps();
        test_nonzero();
        test_saturate();
        test_disable(1'b0);
        test_disable(1'b1);
        test_lines();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule